// File: doc/BRIEF.md
# Strip-to-Segment Hit Merger

This block reduces one half-ladder's worth of per-strip hit flags to a coarse segment hit map for a fast trigger decision. Strip flags arrive serially, one per rising edge of a strobe that travels with the decoded detector data. Each group of 32 neighbouring strips is collapsed into one segment bit, so the 512 strips of a half-ladder become a 16-bit map. A segment bit is set when any strip in its group is hit.

Each transfer is framed by two control pulses. The start pulse clears every live register and arms the block. One long strobe pulse then precedes the data, and it is not taken as a strip. The stop pulse copies the map and two monitoring counters to the outputs and raises a one-cycle valid flag for the trigger path. The first counter counts hit strips. The second counts every strobe rising edge seen while the block is armed. Both counters saturate.

Top module: `strip_seg_merger`

## Requirements
- R1: After reset, `valid_o` is 0 and `seg_map_o`, `hit_cnt_o` and `edge_cnt_o` are all 0.
- R2: A `start_i` pulse clears the strip index, live map and both live counters and arms the block. Strobes and hits seen before the first start, or after a stop and before the next start, have no effect on any later result.
- R3: Once armed, the strobe must stay high for at least LONG_CYC (default 4) consecutive cycles; this is the preamble. Neither the preamble nor any shorter pulse before it is taken as a strip. The first strip is the first strobe rising edge after the preamble has returned low.
- R4: Strip k (counting from 0 in arrival order) sets map bit 15 - floor(k/32). Bit 15 (the MSB) is segment 1, covering strips 0..31, and bit 0 covers strips 480..511. Hits in segments 2, 8 and 11 give 16'b0100000100100000.
- R5: The hit counter increases by one for every accepted strip whose `hit_i` is 1 on its rising strobe edge. It saturates at 2^HIT_W-1.
- R6: The edge counter increases by one for every strobe rising edge while armed, the preamble included. It saturates at 2^EDGE_W-1 (1023 by default).
- R7: Strips after the 512th are ignored by the map and the hit counter.
- R8: A `stop_i` while armed latches the results onto the outputs one cycle later, with `valid_o` high for exactly that one cycle. The outputs then hold until the next latch. A strobe edge in the stop cycle is not counted. A stop while not armed does nothing.
- R9: When `start_i` and `stop_i` are high in the same cycle, start wins: nothing is latched and `valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: clear and arm |
| stop_i | input | 1 | One-cycle pulse: latch results |
| strobe_i | input | 1 | Strip strobe, synchronous to clk |
| hit_i | input | 1 | Hit flag of the strip on a strobe rising edge |
| valid_o | output | 1 | One-cycle result-valid pulse |
| seg_map_o | output | SEG_N (16) | Latched segment map, MSB is segment 1 |
| hit_cnt_o | output | HIT_W (10) | Latched hit-strip count |
| edge_cnt_o | output | EDGE_W (10) | Latched strobe-edge count |

## Verification
The assertions assume that `strobe_i` and `hit_i` are already synchronous to `clk`, that start and stop are single-cycle pulses, and that the strobe stays low for at least one cycle between strips so that each rising edge is seen. The bench drives every input on the falling clock edge and shapes each strip as one high cycle followed by one low cycle. It also sends the preamble as a high run longer than LONG_CYC, so every stimulus meets these assumptions. A behavioural reference model advances on each rising edge, and its latched results are compared with the outputs at every falling edge. Directed checks add fixed expected values for the segment boundaries, the overrun beyond 512 strips and counter saturation.

// File: rtl/seg_merge_pkg.sv
package seg_merge_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ARMED,
        PH_PRE_TAIL,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic edge_seen;
        logic strip;
        logic hit;
    } strip_ev_t;

    function automatic logic [31:0] sat_max(input int w);
        return (32'd1 << w) - 32'd1;
    endfunction

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != MAXV)
            cnt <= cnt + 1'b1;
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt == MAXV && !clr) |=> cnt == MAXV) else $error("sat hold"); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> cnt >= $past(cnt)) else $error("counter wrapped"); // R5
endmodule

// File: rtl/strobe_qualifier.sv
module strobe_qualifier
    import seg_merge_pkg::*;
#(
    parameter int LONG_CYC = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      stop_i,
    input  logic      strobe_i,
    input  logic      hit_i,
    output strip_ev_t ev,
    output logic      active_o
);
    localparam int HC_W = $clog2(LONG_CYC + 1);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(LONG_CYC - 1);

    phase_e          phase;
    logic            strobe_q;
    logic [HC_W-1:0] hi_cnt;
    logic            rise;
    logic            go;

    assign rise     = strobe_i & ~strobe_q;
    assign active_o = (phase != PH_IDLE);
    assign go       = active_o & ~start_i & ~stop_i;

    always_comb begin
        ev           = '0;
        ev.edge_seen = go & rise;
        ev.strip     = go & rise & (phase == PH_DATA);
        ev.hit       = hit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            strobe_q <= 1'b0;
            hi_cnt   <= '0;
        end else begin
            strobe_q <= strobe_i;
            if (start_i) begin
                phase  <= PH_ARMED;
                hi_cnt <= '0;
            end else if (stop_i) begin
                phase  <= PH_IDLE;
                hi_cnt <= '0;
            end else begin
                case (phase)
                    PH_ARMED: begin
                        if (!strobe_i)
                            hi_cnt <= '0;
                        else if (hi_cnt == HC_LAST) begin
                            hi_cnt <= '0;
                            phase  <= PH_PRE_TAIL;
                        end else
                            hi_cnt <= hi_cnt + 1'b1;
                    end
                    PH_PRE_TAIL: if (!strobe_i) phase <= PH_DATA;
                    default: ;
                endcase
            end
        end
    end

    AST_NO_STRIP_BEFORE_PRE: assert property (@(posedge clk) disable iff (rst)
        $past(start_i) |-> !ev.strip) else $error("strip right after start"); // R3
endmodule

// File: rtl/seg_accum.sv
module seg_accum
    import seg_merge_pkg::*;
#(
    parameter int SEG_N      = 16,
    parameter int SEG_STRIPS = 32,
    parameter int HIT_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  strip_ev_t        ev,
    output logic [SEG_N-1:0] map_o,
    output logic [HIT_W-1:0] hits_o
);
    localparam int NSTRIP = SEG_N * SEG_STRIPS;
    localparam int IDX_W  = $clog2(NSTRIP + 1);

    logic [IDX_W-1:0] idx;
    logic             take;
    logic [SEG_N-1:0] set_bits;

    assign take = ev.strip && (idx < IDX_W'(NSTRIP));

    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
        assign set_bits[SEG_N-1-g] = take && ev.hit
            && (idx >= IDX_W'(g * SEG_STRIPS))
            && (idx <  IDX_W'((g + 1) * SEG_STRIPS));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx   <= '0;
            map_o <= '0;
        end else if (take) begin
            idx   <= idx + 1'b1;
            map_o <= map_o | set_bits;
        end
    end

    sat_counter #(.W(HIT_W)) u_hits (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .inc (take & ev.hit),
        .cnt (hits_o)
    );

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        idx <= IDX_W'(NSTRIP)) else $error("index overrun"); // R7
    AST_MAP_GROWS: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (map_o & $past(map_o)) == $past(map_o)) else $error("map bit lost"); // R4
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr |=> (map_o == '0 && hits_o == '0)) else $error("clear failed"); // R2
endmodule

// File: rtl/strip_seg_merger.sv
module strip_seg_merger
    import seg_merge_pkg::*;
#(
    parameter int SEG_N      = 16,
    parameter int SEG_STRIPS = 32,
    parameter int LONG_CYC   = 4,
    parameter int HIT_W      = 10,
    parameter int EDGE_W     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              strobe_i,
    input  logic              hit_i,
    output logic              valid_o,
    output logic [SEG_N-1:0]  seg_map_o,
    output logic [HIT_W-1:0]  hit_cnt_o,
    output logic [EDGE_W-1:0] edge_cnt_o
);
    strip_ev_t         ev;
    logic              active;
    logic [SEG_N-1:0]  live_map;
    logic [HIT_W-1:0]  live_hits;
    logic [EDGE_W-1:0] live_edges;
    logic              do_latch;

    strobe_qualifier #(.LONG_CYC(LONG_CYC)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .strobe_i (strobe_i),
        .hit_i    (hit_i),
        .ev       (ev),
        .active_o (active)
    );

    seg_accum #(.SEG_N(SEG_N), .SEG_STRIPS(SEG_STRIPS), .HIT_W(HIT_W)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .clr    (start_i),
        .ev     (ev),
        .map_o  (live_map),
        .hits_o (live_hits)
    );

    sat_counter #(.W(EDGE_W)) u_edges (
        .clk (clk),
        .rst (rst),
        .clr (start_i),
        .inc (ev.edge_seen),
        .cnt (live_edges)
    );

    assign do_latch = stop_i & active & ~start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o    <= 1'b0;
            seg_map_o  <= '0;
            hit_cnt_o  <= '0;
            edge_cnt_o <= '0;
        end else begin
            valid_o <= do_latch;
            if (do_latch) begin
                seg_map_o  <= live_map;
                hit_cnt_o  <= live_hits;
                edge_cnt_o <= live_edges;
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o) else $error("valid too long"); // R8
    AST_START_BEATS_STOP: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !valid_o) else $error("latched on start"); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stop_i |=> $stable(seg_map_o) && $stable(hit_cnt_o)) else $error("output moved"); // R8
endmodule

// File: tb/tb_strip_seg_merger.sv
module tb_strip_seg_merger;
    localparam int LONG = 4;
    localparam int EMAX = 1023;
    localparam int HMAX = 1023;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, stop = 1'b0, strobe = 1'b0, hit = 1'b0;
    logic        valid;
    logic [15:0] smap;
    logic [9:0]  hcnt, ecnt;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    strip_seg_merger dut (
        .clk(clk), .rst(rst), .start_i(start), .stop_i(stop),
        .strobe_i(strobe), .hit_i(hit), .valid_o(valid),
        .seg_map_o(smap), .hit_cnt_o(hcnt), .edge_cnt_o(ecnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int ph, hc, idx, lhits, ledges, m_hits, m_edges;
    logic [15:0] lmap, m_map;
    bit m_valid, pstb;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; hc = 0; idx = 0; lmap = 0; lhits = 0; ledges = 0; pstb = 0;
            m_valid = 0; m_map = 0; m_hits = 0; m_edges = 0;
        end else begin
            bit rise;
            rise = strobe && !pstb;
            m_valid = 0;
            if (start) begin
                ph = 1; hc = 0; idx = 0; lmap = 0; lhits = 0; ledges = 0;
            end else if (stop && ph != 0) begin
                m_valid = 1; m_map = lmap; m_hits = lhits; m_edges = ledges; ph = 0;
            end else if (ph != 0) begin
                if (rise && ledges < EMAX) ledges++;
                if (ph == 1) begin
                    if (strobe) begin
                        if (hc + 1 >= LONG) begin ph = 2; hc = 0; end else hc++;
                    end else hc = 0;
                end else if (ph == 2) begin
                    if (!strobe) ph = 3;
                end else if (rise && idx < 512) begin
                    if (hit) begin
                        lmap[15 - idx / 32] = 1'b1;
                        if (lhits < HMAX) lhits++;
                    end
                    idx++;
                end
            end
            pstb = strobe;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(valid == m_valid, "R8 valid", valid, m_valid);
            check(smap == m_map, "R4 map", smap, m_map);
            check(hcnt == m_hits, "R5 hits", hcnt, m_hits);
            check(ecnt == m_edges, "R6 edges", ecnt, m_edges);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic do_start();
        start = 1; @(negedge clk); start = 0;
    endtask
    task automatic do_stop();
        stop = 1; @(negedge clk); stop = 0;
    endtask
    task automatic short_pulse();
        strobe = 1; @(negedge clk); strobe = 0; @(negedge clk);
    endtask
    task automatic preamble();
        strobe = 1; repeat (LONG + 2) @(negedge clk); strobe = 0; @(negedge clk);
    endtask
    task automatic strip(input bit h);
        strobe = 1; hit = h; @(negedge clk); strobe = 0; hit = 0; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(valid == 0 && smap == 0 && hcnt == 0 && ecnt == 0, "R1 reset", smap, 0);

        // R2 strobes while idle, R8 stop while idle
        repeat (5) strip(1);
        do_stop();
        check(valid == 0, "R8 stop idle", valid, 0);

        // R3 short pulses before preamble, R4 pattern segments 2,8,11
        do_start();
        short_pulse(); short_pulse();
        preamble();
        for (int k = 0; k < 330; k++) strip(k == 32 || k == 224 || k == 320);
        do_stop();
        check(valid == 1, "R8 valid pulse", valid, 1);
        check(smap == 16'h4120, "R4 pattern", smap, 16'h4120);
        check(hcnt == 3, "R3 R5 hits", hcnt, 3);
        check(ecnt == 333, "R6 edges incl preamble", ecnt, 333);
        @(negedge clk);
        check(valid == 0, "R8 one cycle", valid, 0);
        idle(5);
        check(smap == 16'h4120, "R8 hold", smap, 16'h4120);

        // R7 overrun beyond 512 strips
        do_start();
        preamble();
        for (int k = 0; k < 552; k++) strip(1);
        do_stop();
        check(smap == 16'hFFFF, "R7 map", smap, 16'hFFFF);
        check(hcnt == 512, "R7 hits", hcnt, 512);
        check(ecnt == 553, "R6 edges", ecnt, 553);

        // R4 segment boundaries
        do_start();
        preamble();
        for (int k = 0; k < 512; k++) strip(k == 31 || k == 32 || k == 511);
        do_stop();
        check(smap == 16'hC001, "R4 boundaries", smap, 16'hC001);
        check(hcnt == 3, "R5 boundary hits", hcnt, 3);

        // R6 edge saturation
        do_start();
        preamble();
        for (int k = 0; k < 1100; k++) strip(0);
        do_stop();
        check(ecnt == 1023, "R6 saturate", ecnt, 1023);
        check(smap == 0, "R4 empty", smap, 0);

        // R2 restart clears partial data
        do_start();
        preamble();
        for (int k = 0; k < 40; k++) strip(1);
        do_start();
        preamble();
        strip(0);
        do_stop();
        check(smap == 0, "R2 map cleared", smap, 0);
        check(hcnt == 0, "R2 hits cleared", hcnt, 0);
        check(ecnt == 2, "R2 edges cleared", ecnt, 2);

        // R9 start and stop together
        do_start();
        preamble();
        strip(1);
        start = 1; stop = 1; @(negedge clk); start = 0; stop = 0;
        check(valid == 0, "R9 no latch", valid, 0);
        check(ecnt == 2, "R9 outputs held", ecnt, 2);
        preamble();
        strip(1);
        do_stop();
        check(smap == 16'h8000 && hcnt == 1, "R9 start won", smap, 16'h8000);

        idle(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule